// File: doc/BRIEF.md
# Masked Port Register Bank

This block holds the control and data registers for one byte-wide I/O port whose pins are shared between a microcontroller and a set of programmable-logic output flip-flops (macrocells). The microcontroller reaches every register through a small write-strobe and offset interface with a combinational read path. The pins see an input level, an output value and a per-pin output enable.

A pin is enabled when its direction bit is set or when the logic side asks for it through its own enable term. The upper half of the pins can be switched to open-drain mode, in which an enabled pin only ever pulls low.

The macrocell flip-flops normally take next-state data from the logic side on an update strobe. The microcontroller can also load them directly. A per-bit mask blocks that direct load, and a masked bit keeps following the logic side.

Top module: `port_regbank`

## Requirements
- R1: Offset 0 (pin levels) is read-only and returns the present value of `pin_in` in the same cycle, with no register in the path.
- R2: Offset 1 (output data) is read/write. Reading it returns the last value written, and it drives `pin_out` for push-pull pins.
- R3: `pin_oe[i]` can be 1 only when the direction bit i (offset 2, read/write) or `lg_oe[i]` is 1. For push-pull pins, `pin_oe[i]` equals that OR.
- R4: Offset 5 (enable view) is read-only and returns, per bit, the OR of the direction register and `lg_oe`.
- R5: A write to offset 3 loads `wdata` into every unmasked macrocell flip-flop on the next clock edge. Reading offset 3 returns `mc_q`.
- R6: Offset 4 (macrocell mask) is read/write. A bit at 1 blocks the microcontroller from loading the matching flip-flop, so that bit stays unchanged when no logic update is present.
- R7: When `lg_upd` is 1, each flip-flop takes `lg_next`, except unmasked bits that receive a microcontroller write in the same cycle: for those the write wins.
- R8: Offset 6 (drive) bits 7..4 put pins 7..4 into open-drain mode. Such a pin is enabled only if it is enabled under R3 and its output-data bit is 0, and `pin_out` is then 0. An open-drain pin never drives a 1.
- R9: Drive bits 3..0 are stored and read back but do not affect `pin_out` or `pin_oe`.
- R10: Offset 7 reads 0, and a write to it changes no register.
- R11: After reset every writable register and every macrocell flip-flop is 0, so all pins start as inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `addr` |
| pin_in | input | 8 | Sampled pin levels |
| pin_out | output | 8 | Value driven onto the pins |
| pin_oe | output | 8 | Per-pin driver enable |
| lg_oe | input | 8 | Logic-side output-enable terms |
| lg_next | input | 8 | Logic-side next state for the macrocells |
| lg_upd | input | 1 | Logic-side macrocell update strobe |
| mc_q | output | 8 | Macrocell flip-flop outputs |

## Verification
On every cycle, the assertions check three things. Pins are never enabled without a direction bit or a logic enable. Open-drain pins never drive a 1, and they release when their data bit is 1. Across each clock edge, masked macrocell bits ignore microcontroller writes, and unmasked bits take the written value when a logic update arrives in the same cycle. The bench scenarios are needed to show the rest: register readback values, the combinational path from the pins to the read bus, the inertness of the slew bits and of offset 7, and the full reset state.

// File: rtl/port_rb_pkg.sv
package port_rb_pkg;
  typedef enum logic [2:0] {
    SEL_PIN   = 3'd0,
    SEL_DOUT  = 3'd1,
    SEL_DIR   = 3'd2,
    SEL_MC    = 3'd3,
    SEL_MASK  = 3'd4,
    SEL_ENV   = 3'd5,
    SEL_DRIVE = 3'd6,
    SEL_NONE  = 3'd7
  } reg_sel_e;

  // Next macrocell state: an MCU write lands on unmasked bits, logic update elsewhere.
  function automatic logic [7:0] f_mc_next(
    input logic [7:0] q, input logic [7:0] mask, input logic [7:0] wd,
    input logic mcu_wr, input logic [7:0] lg_d, input logic lg_en);
    logic [7:0] wsel;
    logic [7:0] base;
    wsel = mcu_wr ? ~mask : '0;
    base = lg_en ? lg_d : q;
    return (wd & wsel) | (base & ~wsel);
  endfunction
endpackage

// File: rtl/prb_ctrl_regs.sv
module prb_ctrl_regs #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_dout,
  input  logic         wr_dir,
  input  logic         wr_drive,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] dout_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] drive_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout_q  <= '0;
      dir_q   <= '0;
      drive_q <= '0;
    end else begin
      if (wr_dout)  dout_q  <= wdata;
      if (wr_dir)   dir_q   <= wdata;
      if (wr_drive) drive_q <= wdata;
    end
  end
endmodule

// File: rtl/prb_mcell.sv
module prb_mcell #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_mc,
  input  logic         wr_mask,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] lg_next,
  input  logic         lg_upd,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] mc_q
);
  import port_rb_pkg::*;

  logic [W-1:0] mc_d;
  assign mc_d = f_mc_next(mc_q, mask_q, wdata, wr_mc, lg_next, lg_upd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      mc_q   <= '0;
    end else begin
      if (wr_mask) mask_q <= wdata;
      mc_q <= mc_d;
    end
  end

  // R6
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mc && !lg_upd && !wr_mask) |=> (((mc_q ^ $past(mc_q)) & mask_q) == '0));

  // R7
  mcu_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mc && lg_upd && !wr_mask) |=> ((mc_q & ~mask_q) == ($past(wdata) & ~mask_q)));

  // R7
  lg_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lg_upd && !wr_mask) |=> ((mc_q & mask_q) == ($past(lg_next) & mask_q)));
endmodule

// File: rtl/prb_pin_drv.sv
module prb_pin_drv #(
  parameter int W = 8
) (
  input  logic [W-1:0] dout_q,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] drive_q,
  input  logic [W-1:0] lg_oe,
  output logic [W-1:0] en_eff,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe
);
  localparam int OD_LO = W / 2;

  assign en_eff = dir_q | lg_oe;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i >= OD_LO) begin : g_od
      assign pin_oe[i]  = en_eff[i] & (drive_q[i] ? ~dout_q[i] : 1'b1);
      assign pin_out[i] = dout_q[i] & ~drive_q[i];
    end else begin : g_pp
      assign pin_oe[i]  = en_eff[i];
      assign pin_out[i] = dout_q[i];
    end
  end
endmodule

// File: rtl/port_regbank.sv
module port_regbank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [2:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  input  logic [W-1:0] lg_oe,
  input  logic [W-1:0] lg_next,
  input  logic         lg_upd,
  output logic [W-1:0] mc_q
);
  import port_rb_pkg::*;

  localparam int OD_LO = W / 2;
  localparam logic [W-1:0] OD_MASK = {{(W-OD_LO){1'b1}}, {OD_LO{1'b0}}};

  logic [W-1:0] dout_q, dir_q, drive_q, mask_q, en_eff;
  logic wr_dout, wr_dir, wr_drive, wr_mc, wr_mask;
  logic [W-1:0] od_sel;

  assign wr_dout  = wr_en && (addr == SEL_DOUT);
  assign wr_dir   = wr_en && (addr == SEL_DIR);
  assign wr_drive = wr_en && (addr == SEL_DRIVE);
  assign wr_mc    = wr_en && (addr == SEL_MC);
  assign wr_mask  = wr_en && (addr == SEL_MASK);
  assign od_sel   = drive_q & OD_MASK;

  prb_ctrl_regs #(.W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_dout(wr_dout), .wr_dir(wr_dir),
    .wr_drive(wr_drive), .wdata(wdata), .dout_q(dout_q), .dir_q(dir_q),
    .drive_q(drive_q));

  prb_mcell #(.W(W)) u_mc (
    .clk(clk), .rst_n(rst_n), .wr_mc(wr_mc), .wr_mask(wr_mask),
    .wdata(wdata), .lg_next(lg_next), .lg_upd(lg_upd),
    .mask_q(mask_q), .mc_q(mc_q));

  prb_pin_drv #(.W(W)) u_pin (
    .dout_q(dout_q), .dir_q(dir_q), .drive_q(drive_q), .lg_oe(lg_oe),
    .en_eff(en_eff), .pin_out(pin_out), .pin_oe(pin_oe));

  always_comb begin
    unique case (addr)
      SEL_PIN:   rdata = pin_in;
      SEL_DOUT:  rdata = dout_q;
      SEL_DIR:   rdata = dir_q;
      SEL_MC:    rdata = mc_q;
      SEL_MASK:  rdata = mask_q;
      SEL_ENV:   rdata = en_eff;
      SEL_DRIVE: rdata = drive_q;
      default:   rdata = '0;
    endcase
  end

  // R3
  oe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & ~(dir_q | lg_oe)) == '0);

  // R8
  od_no_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & pin_out & od_sel) == '0);

  // R8
  od_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & od_sel & dout_q) == '0);
endmodule

// File: tb/tb_port_regbank.sv
module tb_port_regbank;
  logic clk = 0, rst_n = 0, wr_en = 0, lg_upd = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, pin_in = 0, lg_oe = 0, lg_next = 0;
  logic [7:0] rdata, pin_out, pin_oe, mc_q;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  port_regbank dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .lg_oe(lg_oe), .lg_next(lg_next), .lg_upd(lg_upd),
    .mc_q(mc_q));

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 1; a < 8; a++) begin rd(3'(a), v); chk("R11 reg", v, 8'h00); end
    chk("R11 oe", pin_oe, 8'h00);
    chk("R11 mc", mc_q, 8'h00);
  endtask

  task automatic t_pins();
    logic [7:0] v;
    pin_in = 8'hA5; rd(3'd0, v); chk("R1 a5", v, 8'hA5);
    pin_in = 8'h3C; #1; chk("R1 follow", rdata, 8'h3C);
    wr(3'd0, 8'hFF); rd(3'd0, v); chk("R1 ro", v, 8'h3C);
  endtask

  task automatic t_dout_dir();
    logic [7:0] v;
    wr(3'd1, 8'h96); rd(3'd1, v); chk("R2 readback", v, 8'h96);
    chk("R2 pin_out", pin_out, 8'h96);
    wr(3'd2, 8'h0F); lg_oe = 8'h30; #1;
    chk("R3 oe or", pin_oe, 8'h3F);
    rd(3'd2, v); chk("R3 dir rb", v, 8'h0F);
    rd(3'd5, v); chk("R4 env", v, 8'h3F);
    wr(3'd5, 8'h00); rd(3'd5, v); chk("R4 ro", v, 8'h3F);
    lg_oe = 8'h00; #1; chk("R3 dir only", pin_oe, 8'h0F);
  endtask

  task automatic t_mcell();
    logic [7:0] v;
    wr(3'd3, 8'h5A); chk("R5 load", mc_q, 8'h5A);
    rd(3'd3, v); chk("R5 read", v, 8'h5A);
    wr(3'd4, 8'hF0); rd(3'd4, v); chk("R6 mask rb", v, 8'hF0);
    wr(3'd3, 8'h0F); chk("R6 blocked", mc_q, 8'h5F);
    // R7: logic update, then same-cycle collision
    @(negedge clk); lg_upd = 1; lg_next = 8'h3C;
    @(negedge clk); lg_upd = 0; chk("R7 lg", mc_q, 8'h3C);
    @(negedge clk); lg_upd = 1; lg_next = 8'hAA; wr_en = 1; addr = 3'd3; wdata = 8'h55;
    @(negedge clk); lg_upd = 0; wr_en = 0; chk("R7 collide", mc_q, 8'hA5);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_drive();
    logic [7:0] v;
    wr(3'd2, 8'hFF); wr(3'd1, 8'h5A);
    wr(3'd6, 8'hF0); #1;
    // pins 7..4 open drain: dout 0101 -> drive pins 7,5 low, release 6,4
    chk("R8 oe", pin_oe, 8'hAF);
    chk("R8 out", pin_out, 8'h0A);
    wr(3'd6, 8'h0F); #1;
    chk("R9 oe", pin_oe, 8'hFF);
    chk("R9 out", pin_out, 8'h5A);
    rd(3'd6, v); chk("R9 rb", v, 8'h0F);
    wr(3'd7, 8'hFF); rd(3'd7, v); chk("R10 read", v, 8'h00);
    rd(3'd1, v); chk("R10 dout", v, 8'h5A);
    rd(3'd2, v); chk("R10 dir", v, 8'hFF);
    rd(3'd6, v); chk("R10 drive", v, 8'h0F);
    chk("R10 mc", mc_q, 8'hA5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_pins(); t_dout_dir(); t_mcell(); t_drive();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (5000) @(posedge clk); errors++; checks++;
        $display("FAIL watchdog got timeout expected completion"); end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule